// File: doc/BRIEF.md
# Reader Command Frame Parser for a Contactless Tag

This block sits behind the bit demodulator of a low-frequency contactless tag. It takes one decoded bit at a time from the reader, marked by a bit strobe. It also takes a strobe that closes the frame. When the frame closes, the block decides what the reader asked for. The answer is a block write, a power-on-reset request, a wake-up/select request, or a rejection that sends the tag back to plain read mode.

The frame shape depends on the leading two-bit opcode and on whether password protection is switched on. The bit count at the close of the frame has to equal the length that the opcode and mode call for. The block tracks which memory page the last accepted command chose, and whether the tag has been selected by a wake-up. Test-mode writes are refused without any response once the configured master-key nibble holds 6.

Top module: `rfid_cmd_parser`

## Requirements
- R1: The first two bits of a frame form the opcode, first bit in the upper position. Opcode 2'b10 addresses page 0 and 2'b11 addresses page 1, for both writes and wake-ups, and the page is shown on `wr_page`.
- R2: Opcode 2'b00 in a frame of exactly 2 bits pulses `por_req` and clears `selected`. Any other length with this opcode is invalid.
- R3: Opcode 2'b01 in a 38-bit frame, laid out as a standard write, pulses `wr_req` with `wr_test`=1 and `wr_page`=0, as long as `master_key` is not 4'd6. When `master_key` is 4'd6, such a frame produces no pulse at all and changes no state.
- R4: With `pwd_en`=0, a 38-bit frame with opcode 1x is a write. After the opcode it carries the lock bit, then 32 data bits sent MSB first, then a 3-bit block address sent MSB first. The frame pulses `wr_req` with those fields and with `wr_test`=0.
- R5: With `pwd_en`=1, a write is 70 bits long. A 32-bit password, sent MSB first, sits between the opcode and the lock bit. The write is accepted only if the password equals `pwd_ref`; otherwise the frame is invalid. A 38-bit write is invalid in this mode.
- R6: A 34-bit frame made of an opcode 1x and a 32-bit password is a wake-up. If the password equals `pwd_ref`, the frame pulses `wake_req` and sets `selected`; otherwise the frame is invalid. This holds whatever the value of `pwd_en`.
- R7: Every other frame pulses `cmd_invalid` and leaves `sel_page` and `selected` unchanged. This covers any length not listed above and a frame that closes with fewer than 2 bits.
- R8: `sel_page` changes only when an opcode 1x write or wake-up is accepted, and it then takes that command's page.
- R9: Each result is a one-cycle pulse in the cycle after `frame_end` is sampled, and at most one result fires per frame. A bit whose strobe coincides with `frame_end` counts as part of the closing frame.
- R10: After reset, all pulses are low, `sel_page` is 0, `selected` is 0, and the parser waits for a first opcode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | One decoded bit is present this cycle |
| bit_val | input | 1 | Value of the decoded bit |
| frame_end | input | 1 | Closes the current frame |
| pwd_en | input | 1 | Password protection switched on |
| pwd_ref | input | 32 | Stored password |
| master_key | input | 4 | Master-key nibble from configuration |
| wr_req | output | 1 | Write accepted (pulse) |
| wr_test | output | 1 | The accepted write is a test-mode write |
| wr_page | output | 1 | Page of the accepted write |
| wr_lock | output | 1 | Lock bit of the accepted write |
| wr_addr | output | 3 | Block address of the accepted write |
| wr_data | output | 32 | Data of the accepted write |
| por_req | output | 1 | Power-on-reset request (pulse) |
| wake_req | output | 1 | Wake-up accepted (pulse) |
| cmd_invalid | output | 1 | Frame rejected, back to read mode (pulse) |
| sel_page | output | 1 | Page chosen by the last accepted opcode 1x command |
| selected | output | 1 | Tag selected by a wake-up |

## Verification
Two events can fall in the same cycle: the strobe of the last bit and the end-of-frame strobe. The bench sends some frames with the final bit and `frame_end` driven together, and others with `frame_end` one cycle after the final bit. The scoreboard expects the same decision in both cases: the coincident bit must be counted, so a 38-bit write stays a write rather than being rejected as 37 bits. The page tracking is compared on every result, which shows that the coincident case does not shift the decoded fields.

// File: rtl/rfid_cmd_pkg.sv
package rfid_cmd_pkg;
    localparam int OP_W     = 2;
    localparam int PWD_W    = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int KEY_W    = 4;
    localparam logic [KEY_W-1:0] KEY_LOCKED = 4'd6;

    localparam int LEN_POR  = OP_W;
    localparam int LEN_WAKE = OP_W + PWD_W;
    localparam int LEN_STD  = OP_W + 1 + DATA_W + ADDR_W;
    localparam int LEN_PROT = LEN_STD + PWD_W;
    localparam int SR_W     = LEN_PROT - OP_W;
    localparam int CNT_SAT  = LEN_PROT + 1;
    localparam int CNT_W    = $clog2(CNT_SAT + 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SR_W-1:0]  sr_t;

    typedef enum logic [2:0] {
        K_NONE, K_WRITE, K_POR, K_WAKE, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic                page;
        logic                test;
        logic                lock;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } dec_t;
endpackage

// File: rtl/rfid_frame_shift.sv
module rfid_frame_shift
    import rfid_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_vld,
    input  logic            bit_val,
    input  logic            frame_end,
    output cnt_t            cnt_nx,
    output sr_t             sr_nx,
    output logic [OP_W-1:0] op_nx
);
    cnt_t            cnt_q;
    sr_t             sr_q;
    logic [OP_W-1:0] op_q;

    always_comb begin
        cnt_nx = cnt_q;
        sr_nx  = sr_q;
        op_nx  = op_q;
        if (bit_vld) begin
            if (cnt_q != cnt_t'(CNT_SAT)) begin
                cnt_nx = cnt_q + cnt_t'(1);
            end
            sr_nx = {sr_q[SR_W-2:0], bit_val};
            if (cnt_q == cnt_t'(0)) begin
                op_nx[1] = bit_val;
            end
            if (cnt_q == cnt_t'(1)) begin
                op_nx[0] = bit_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
            op_q  <= '0;
        end else if (frame_end) begin
            cnt_q <= '0;
            sr_q  <= '0;
            op_q  <= '0;
        end else begin
            cnt_q <= cnt_nx;
            sr_q  <= sr_nx;
            op_q  <= op_nx;
        end
    end
endmodule

// File: rtl/rfid_frame_decode.sv
module rfid_frame_decode
    import rfid_cmd_pkg::*;
(
    input  cnt_t             cnt,
    input  sr_t              sr,
    input  logic [OP_W-1:0]  op,
    input  logic             pwd_en,
    input  logic [PWD_W-1:0] pwd_ref,
    input  logic [KEY_W-1:0] master_key,
    output dec_t             dec
);
    localparam int FLD_W = 1 + DATA_W + ADDR_W;

    logic pwd_ok_prot;
    logic pwd_ok_wake;

    always_comb begin
        pwd_ok_prot = (sr[FLD_W +: PWD_W] == pwd_ref);
        pwd_ok_wake = (sr[0 +: PWD_W] == pwd_ref);

        dec.kind = K_BAD;
        dec.page = op[0];
        dec.test = 1'b0;
        dec.lock = sr[ADDR_W + DATA_W];
        dec.addr = sr[0 +: ADDR_W];
        dec.data = sr[ADDR_W +: DATA_W];

        if (cnt < cnt_t'(OP_W)) begin
            dec.kind = K_BAD;
        end else begin
            unique case (op)
                2'b00: dec.kind = (cnt == cnt_t'(LEN_POR)) ? K_POR : K_BAD;
                2'b01: begin
                    dec.page = 1'b0;
                    dec.test = 1'b1;
                    if (master_key == KEY_LOCKED) begin
                        dec.kind = K_NONE;
                    end else if (cnt == cnt_t'(LEN_STD)) begin
                        dec.kind = K_WRITE;
                    end else begin
                        dec.kind = K_BAD;
                    end
                end
                default: begin
                    if (cnt == cnt_t'(LEN_WAKE)) begin
                        dec.kind = pwd_ok_wake ? K_WAKE : K_BAD;
                    end else if (cnt == cnt_t'(LEN_STD) && !pwd_en) begin
                        dec.kind = K_WRITE;
                    end else if (cnt == cnt_t'(LEN_PROT) && pwd_en && pwd_ok_prot) begin
                        dec.kind = K_WRITE;
                    end else begin
                        dec.kind = K_BAD;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rfid_cmd_parser.sv
module rfid_cmd_parser
    import rfid_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              frame_end,
    input  logic              pwd_en,
    input  logic [PWD_W-1:0]  pwd_ref,
    input  logic [KEY_W-1:0]  master_key,
    output logic              wr_req,
    output logic              wr_test,
    output logic              wr_page,
    output logic              wr_lock,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              por_req,
    output logic              wake_req,
    output logic              cmd_invalid,
    output logic              sel_page,
    output logic              selected
);
    typedef struct packed {
        logic              wr_req;
        logic              wr_test;
        logic              wr_page;
        logic              wr_lock;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              por_req;
        logic              wake_req;
        logic              cmd_invalid;
        logic              sel_page;
        logic              selected;
    } st_t;

    cnt_t            cnt_nx;
    sr_t             sr_nx;
    logic [OP_W-1:0] op_nx;
    dec_t            dec;
    st_t             st_d;
    st_t             st_q;

    rfid_frame_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .frame_end (frame_end),
        .cnt_nx    (cnt_nx),
        .sr_nx     (sr_nx),
        .op_nx     (op_nx)
    );

    rfid_frame_decode u_decode (
        .cnt        (cnt_nx),
        .sr         (sr_nx),
        .op         (op_nx),
        .pwd_en     (pwd_en),
        .pwd_ref    (pwd_ref),
        .master_key (master_key),
        .dec        (dec)
    );

    always_comb begin
        st_d             = st_q;
        st_d.wr_req      = 1'b0;
        st_d.por_req     = 1'b0;
        st_d.wake_req    = 1'b0;
        st_d.cmd_invalid = 1'b0;
        if (frame_end) begin
            unique case (dec.kind)
                K_WRITE: begin
                    st_d.wr_req  = 1'b1;
                    st_d.wr_test = dec.test;
                    st_d.wr_page = dec.page;
                    st_d.wr_lock = dec.lock;
                    st_d.wr_addr = dec.addr;
                    st_d.wr_data = dec.data;
                    if (!dec.test) begin
                        st_d.sel_page = dec.page;
                    end
                end
                K_POR: begin
                    st_d.por_req  = 1'b1;
                    st_d.selected = 1'b0;
                end
                K_WAKE: begin
                    st_d.wake_req = 1'b1;
                    st_d.selected = 1'b1;
                    st_d.sel_page = dec.page;
                end
                K_BAD:   st_d.cmd_invalid = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req      = st_q.wr_req;
    assign wr_test     = st_q.wr_test;
    assign wr_page     = st_q.wr_page;
    assign wr_lock     = st_q.wr_lock;
    assign wr_addr     = st_q.wr_addr;
    assign wr_data     = st_q.wr_data;
    assign por_req     = st_q.por_req;
    assign wake_req    = st_q.wake_req;
    assign cmd_invalid = st_q.cmd_invalid;
    assign sel_page    = st_q.sel_page;
    assign selected    = st_q.selected;
endmodule

// File: rtl/rfid_cmd_parser_chk.sv
module rfid_cmd_parser_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_end,
    input logic wr_req,
    input logic wr_test,
    input logic wr_page,
    input logic por_req,
    input logic wake_req,
    input logic cmd_invalid,
    input logic sel_page,
    input logic selected
);
    a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_req, por_req, wake_req, cmd_invalid}));

    a_r9_after_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || por_req || wake_req || cmd_invalid) |-> $past(frame_end));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || por_req || wake_req || cmd_invalid) |=>
        !(wr_req || por_req || wake_req || cmd_invalid) || $past(frame_end));

    a_r8_page_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_page) |-> (wake_req || (wr_req && !wr_test)));

    a_r7_invalid_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_invalid |-> ($stable(sel_page) && $stable(selected)));

    a_r6_wake_selects: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> selected);

    a_r2_por_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |-> !selected);

    a_r3_test_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_test) |-> !wr_page);
endmodule

bind rfid_cmd_parser rfid_cmd_parser_chk u_chk (.*);

// File: tb/rfid_cmd_parser_bench.sv
module rfid_cmd_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_val = 1'b0;
    logic        frame_end = 1'b0;
    logic        pwd_en = 1'b0;
    logic [31:0] pwd_ref = 32'hC3A5_0F96;
    logic [3:0]  master_key = 4'd0;
    logic        wr_req, wr_test, wr_page, wr_lock;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        por_req, wake_req, cmd_invalid, sel_page, selected;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit finished = 0;

    // 50 MHz
    always #10 clk = ~clk;

    rfid_cmd_parser u_rfid_cmd_parser (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .frame_end(frame_end), .pwd_en(pwd_en), .pwd_ref(pwd_ref),
        .master_key(master_key), .wr_req(wr_req), .wr_test(wr_test),
        .wr_page(wr_page), .wr_lock(wr_lock), .wr_addr(wr_addr),
        .wr_data(wr_data), .por_req(por_req), .wake_req(wake_req),
        .cmd_invalid(cmd_invalid), .sel_page(sel_page), .selected(selected)
    );

    // kind: 1 write, 2 por, 3 wake, 4 invalid
    typedef struct {
        int         kind;
        bit         test;
        bit         page;
        bit         lock;
        bit [2:0]   addr;
        bit [31:0]  data;
        bit         sp;
        bit         sel;
    } exp_t;

    exp_t q[$];
    bit m_sp = 1'b0;
    bit m_sel = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input string req, input int kind, input bit test,
                        input bit page, input bit lock, input bit [2:0] addr,
                        input bit [31:0] data);
        exp_t e;
        if (kind == 1 && !test) m_sp = page;
        if (kind == 3) begin m_sp = page; m_sel = 1'b1; end
        if (kind == 2) m_sel = 1'b0;
        e.kind = kind; e.test = test; e.page = page; e.lock = lock;
        e.addr = addr; e.data = data; e.sp = m_sp; e.sel = m_sel;
        q.push_back(e);
    endtask

    task automatic send(input logic [71:0] fr, input int len, input bit tie);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_val = fr[i];
            frame_end = tie && (i == 0);
            @(negedge clk);
            bit_vld = 1'b0;
            frame_end = 1'b0;
        end
        if (!tie || len == 0) begin
            @(negedge clk);
            frame_end = 1'b1;
            @(negedge clk);
            frame_end = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R9", "result pending after frame", q.size(), 0);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (wr_req || por_req || wake_req || cmd_invalid)) begin
            int k;
            exp_t e;
            pulses++;
            k = wr_req ? 1 : por_req ? 2 : wake_req ? 3 : 4;
            if (q.size() == 0) begin
                chk(1'b0, "R9", "unexpected result kind", k, 0);
            end else begin
                e = q.pop_front();
                chk(k == e.kind, "R1-kind", "result kind", k, e.kind);
                if (e.kind == 1) begin
                    chk({wr_test, wr_page, wr_lock, wr_addr} ==
                        {e.test, e.page, e.lock, e.addr}, "R4", "write fields",
                        {wr_test, wr_page, wr_lock, wr_addr},
                        {e.test, e.page, e.lock, e.addr});
                    chk(wr_data == e.data, "R4", "write data", wr_data, e.data);
                end
                chk(sel_page == e.sp, "R8", "sel_page", sel_page, e.sp);
                chk(selected == e.sel, "R6", "selected", selected, e.sel);
            end
        end
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({wr_req, por_req, wake_req, cmd_invalid, sel_page, selected} == 6'b0,
            "R10", "reset outputs",
            {wr_req, por_req, wake_req, cmd_invalid, sel_page, selected}, 0);

        // R1 R4: page 0 write, frame_end after last bit
        push("R4", 1, 0, 0, 0, 3'd5, 32'h8000_0001);
        send({34'd0, 2'b10, 1'b0, 32'h8000_0001, 3'b101}, 38, 0);
        // R1 R4 R9: page 1 write, last bit together with frame_end
        push("R9", 1, 0, 1, 1, 3'd2, 32'hDEAD_BEEF);
        send({34'd0, 2'b11, 1'b1, 32'hDEAD_BEEF, 3'b010}, 38, 1);
        chk(sel_page == 1'b1, "R1", "page after 11 write", sel_page, 1);

        // R2: por
        push("R2", 2, 0, 0, 0, 0, 0);
        send({70'd0, 2'b00}, 2, 1);
        // R2 R7: por opcode with extra bit
        push("R7", 4, 0, 0, 0, 0, 0);
        send({69'd0, 3'b001}, 3, 0);
        // R7: 37-bit write
        push("R7", 4, 0, 0, 0, 0, 0);
        send({35'd0, 2'b10, 1'b0, 32'h1234_5678, 2'b11}, 37, 0);
        chk(sel_page == 1'b1, "R7", "page held after invalid", sel_page, 1);
        // R7: empty frame and 1-bit frame
        push("R7", 4, 0, 0, 0, 0, 0);
        send(72'd0, 0, 0);
        push("R7", 4, 0, 0, 0, 0, 0);
        send(72'd1, 1, 1);

        // R3: test write, key open
        master_key = 4'd5;
        push("R3", 1, 1, 0, 1, 3'd7, 32'h0F0F_A5A5);
        send({34'd0, 2'b01, 1'b1, 32'h0F0F_A5A5, 3'b111}, 38, 0);
        chk(sel_page == 1'b1, "R3", "test write keeps page", sel_page, 1);
        // R3: key locked, ignored
        master_key = 4'd6;
        p0 = pulses;
        send({34'd0, 2'b01, 1'b1, 32'hFFFF_FFFF, 3'b000}, 38, 0);
        chk(pulses == p0, "R3", "locked test write pulses", pulses - p0, 0);
        chk(sel_page == 1'b1, "R3", "locked test keeps page", sel_page, 1);

        // R5: protected write
        pwd_en = 1'b1;
        push("R5", 1, 0, 0, 1, 3'd3, 32'h5555_AAAA);
        send({2'b00, 2'b10, pwd_ref, 1'b1, 32'h5555_AAAA, 3'b011}, 70, 1);
        push("R5", 4, 0, 0, 0, 0, 0);
        send({2'b00, 2'b11, pwd_ref ^ 32'h1, 1'b0, 32'h0, 3'b000}, 70, 0);
        chk(sel_page == 1'b0, "R5", "page after bad password", sel_page, 0);
        push("R5", 4, 0, 0, 0, 0, 0);
        send({34'd0, 2'b11, 1'b0, 32'h0, 3'b000}, 38, 0);

        // R6: wake-up
        pwd_en = 1'b0;
        push("R6", 4, 0, 0, 0, 0, 0);
        send({38'd0, 2'b11, ~pwd_ref}, 34, 0);
        chk(selected == 1'b0, "R6", "selected after bad wake", selected, 0);
        push("R6", 3, 0, 1, 0, 0, 0);
        send({38'd0, 2'b11, pwd_ref}, 34, 1);
        chk(selected == 1'b1, "R6", "selected after wake", selected, 1);
        // R2: por clears selection
        push("R2", 2, 0, 0, 0, 0, 0);
        send({70'd0, 2'b00}, 2, 0);
        chk(selected == 1'b0, "R2", "selected after por", selected, 0);
        chk(sel_page == 1'b1, "R8", "page after por", sel_page, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule